// File: doc/BRIEF.md
# Dual-Lane Packed Fixed-Point Multiply-Accumulate Element

This processing element multiplies a signed 32-bit fixed-point weight by an activation word and adds the product into a wide accumulator once per valid cycle. A runtime mode input reinterprets the activation word. In full mode the word is one signed 32-bit activation. In packed mode it carries two signed 16-bit activations, and each is multiplied by the same weight into its own accumulator. Packed mode gives two products per cycle while the weight stays at 32 bits. The two lanes can hold two neurons of one layer, or the same neuron for two batch samples.

Training begins in full mode and moves to packed mode once activations are quantized. The mode input stands in for the controller that makes that switch. The accumulators are read out continuously in activation format. The product carries the weight's fractional bits, so readout drops `FRAC_W` fractional bits. It either rounds and saturates or floors and wraps, as a control input selects. A result-valid flag marks the cycle after each accepted sample. A mode change requested while data is still accumulated is refused and reported.

Top module: `pk_mac`

## Requirements
- R1: After reset, both results read 0, `res_valid_o` and `err_o` are 0, and the element is in full mode with empty accumulators.
- R2: In full mode, an accepted sample adds signed(`act_i`) × signed(`wgt_i`) to accumulator 0. `res0_o` is that accumulator shifted right by `FRAC_W` bits (default 16) and limited to 32 bits. `res1_o` reads 0.
- R3: In packed mode, lane 0 takes signed `act_i[15:0]` and lane 1 takes signed `act_i[31:16]`. Each is multiplied by signed `wgt_i` and added to its own accumulator. Each lane is read out through `res0_o`/`res1_o`, limited to 16 bits and sign-extended to 32.
- R4: The lanes never carry into each other. Lane 1's result depends only on lane 1's operands, whatever lane 0 accumulates.
- R5: `clear_i` together with `valid_i` loads the accumulators with the current products. `clear_i` without `valid_i` sets both accumulators to zero.
- R6: `res_valid_o` is 1 in the cycle after a sample is accepted, and 0 otherwise. The results in that cycle include the sample.
- R7: With `sat_round_i`=1, readout rounds to nearest, and ties go away from zero (+2.5 → 3, −0.25 → 0).
- R8: With `sat_round_i`=1, a result beyond the output range is clamped to the most positive or most negative value. That range is 32 bits in full mode and 16 bits in packed mode.
- R9: With `sat_round_i`=0, readout floors (arithmetic shift) and keeps only the low 32 bits in full mode, or the low 16 bits sign-extended in packed mode.
- R10: A valid sample whose mode differs from the current accumulation is refused unless the accumulators are empty or `clear_i` is 1. A refused sample leaves the accumulators unchanged, gives `err_o`=1 and `res_valid_o`=0 in the next cycle, and leaves the mode unchanged.
- R11: With `valid_i` and `clear_i` both 0, the accumulators and results stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| act_i | input | AW (32) | Activation word: one full activation or two packed lanes |
| wgt_i | input | WW (32) | Signed fixed-point weight |
| packed_i | input | 1 | 1 = two 16-bit lanes, 0 = one 32-bit activation |
| valid_i | input | 1 | Sample present this cycle |
| clear_i | input | 1 | Start a new dot product |
| sat_round_i | input | 1 | 1 = round and saturate on readout, 0 = floor and wrap |
| res0_o | output | AW (32) | Lane 0 / full-mode result |
| res1_o | output | AW (32) | Lane 1 result, 0 in full mode |
| res_valid_o | output | 1 | A sample was accepted in the previous cycle |
| err_o | output | 1 | A mode change was refused in the previous cycle |

## Verification
The assertions take for granted that the accumulators never wrap. The sum of products in one dot product must stay inside the guard bits above the widest product. The stimulus therefore starts a new dot product with `clear_i` before values could grow large, and uses extreme operands only in short runs. The assertions also take for granted that `sat_round_i` is held steady around the sampling edge. The stimulus changes it only at the falling edge.

// File: rtl/pk_mac.sv
module pk_mac #(
  parameter int AW     = 32,
  parameter int WW     = 32,
  parameter int FRAC_W = 16,
  parameter int GUARD  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] act_i,
  input  logic [WW-1:0] wgt_i,
  input  logic          packed_i,
  input  logic          valid_i,
  input  logic          clear_i,
  input  logic          sat_round_i,
  output logic [AW-1:0] res0_o,
  output logic [AW-1:0] res1_o,
  output logic          res_valid_o,
  output logic          err_o
);

  localparam int LW   = AW / 2;
  localparam int ACCW = AW + WW + GUARD;

  logic signed [ACCW-1:0] acc0_q, acc1_q;
  logic signed [ACCW-1:0] x_lo, x_hi, x_full, x_w;
  logic signed [ACCW-1:0] prod0, prod1;
  logic                   mode_q, empty_q;

  assign x_lo   = {{(ACCW-LW){act_i[LW-1]}}, act_i[LW-1:0]};
  assign x_hi   = {{(ACCW-LW){act_i[AW-1]}}, act_i[AW-1:LW]};
  assign x_full = {{(ACCW-AW){act_i[AW-1]}}, act_i};
  assign x_w    = {{(ACCW-WW){wgt_i[WW-1]}}, wgt_i};

  assign prod0 = packed_i ? x_lo * x_w : x_full * x_w;
  assign prod1 = packed_i ? x_hi * x_w : '0;

  wire mode_bad = (packed_i != mode_q) && !empty_q && !clear_i;
  wire take     = valid_i && !mode_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc0_q      <= '0;
      acc1_q      <= '0;
      mode_q      <= 1'b0;
      empty_q     <= 1'b1;
      res_valid_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      res_valid_o <= take;
      err_o       <= valid_i && mode_bad;
      if (take) begin
        mode_q  <= packed_i;
        empty_q <= 1'b0;
        acc0_q  <= clear_i ? prod0 : acc0_q + prod0;
        acc1_q  <= clear_i ? prod1 : acc1_q + prod1;
      end else if (clear_i) begin
        acc0_q  <= '0;
        acc1_q  <= '0;
        empty_q <= 1'b1;
      end
    end
  end

  function automatic logic [AW-1:0] readout(input logic signed [ACCW-1:0] a,
                                            input logic pk, input logic sr);
    logic signed [ACCW-1:0] half, t, mx, mn;
    half = '0;
    half[FRAC_W-1] = 1'b1;
    mx = '0;
    mn = '1;
    if (pk) begin
      mx[LW-2:0] = '1;
      mn[LW-2:0] = '0;
    end else begin
      mx[AW-2:0] = '1;
      mn[AW-2:0] = '0;
    end
    if (sr) begin
      t = (a + (a[ACCW-1] ? half - 1 : half)) >>> FRAC_W;
      if (t > mx)      readout = mx[AW-1:0];
      else if (t < mn) readout = mn[AW-1:0];
      else             readout = t[AW-1:0];
    end else begin
      t = a >>> FRAC_W;
      readout = pk ? {{(AW-LW){t[LW-1]}}, t[LW-1:0]} : t[AW-1:0];
    end
  endfunction

  assign res0_o = readout(acc0_q, mode_q, sat_round_i);
  assign res1_o = readout(acc1_q, mode_q, sat_round_i);

  // R6
  res_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(valid_i));

  // R10
  err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(valid_i && !clear_i) && !res_valid_o));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(clear_i || empty_q));

  // R4
  lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (acc1_q == '0));

  // R8
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_round_i && mode_q) |->
      ((res0_o[AW-1:LW-1] == '0 || res0_o[AW-1:LW-1] == '1) &&
       (res1_o[AW-1:LW-1] == '0 || res1_o[AW-1:LW-1] == '1)));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i && !valid_i) |-> (acc0_q == '0 && acc1_q == '0));

endmodule

// File: tb/pk_mac_bench.sv
module pk_mac_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] act, wgt;
  logic        pk_in, valid, clear, sr;
  logic [31:0] res0, res1;
  logic        res_valid, err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  longint m0, m1;
  bit     mpk, mempty;

  always #(CLK_PERIOD/2) clk = ~clk;

  pk_mac u_pk_mac (
    .clk(clk), .rst_n(rst_n), .act_i(act), .wgt_i(wgt),
    .packed_i(pk_in), .valid_i(valid), .clear_i(clear), .sat_round_i(sr),
    .res0_o(res0), .res1_o(res1), .res_valid_o(res_valid), .err_o(err)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] exp);
    total++;
    if (actual !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, actual, exp);
    end
  endtask

  function automatic longint s16(input logic [15:0] x);
    return longint'(signed'(x));
  endfunction

  function automatic longint s32(input logic [31:0] x);
    return longint'(signed'(x));
  endfunction

  function automatic logic [31:0] rd(input longint a, input bit p, input bit r);
    longint t, mx, mn;
    mx = p ? 64'sd32767 : 64'sd2147483647;
    mn = -mx - 1;
    if (r) begin
      t = (a < 0) ? (a + 32767) >>> 16 : (a + 32768) >>> 16;
      if (t > mx) t = mx;
      if (t < mn) t = mn;
      return t[31:0];
    end
    t = a >>> 16;
    return p ? {{16{t[15]}}, t[15:0]} : t[31:0];
  endfunction

  task automatic op(input logic [31:0] a, input logic [31:0] w, input bit p,
                    input bit v, input bit c);
    bit e, ok;
    longint p0, p1;
    act = a; wgt = w; pk_in = p; valid = v; clear = c;
    e  = v && (p != mpk) && !mempty && !c;
    ok = v && !e;
    p0 = p ? s16(a[15:0]) * s32(w) : s32(a) * s32(w);
    p1 = p ? s16(a[31:16]) * s32(w) : 0;
    if (ok) begin
      m0 = c ? p0 : m0 + p0;
      m1 = c ? p1 : m1 + p1;
      mpk = p; mempty = 0;
    end else if (c) begin
      m0 = 0; m1 = 0; mempty = 1;
    end
    @(negedge clk);
    valid = 0; clear = 0;
    chk("R6 res_valid", {31'd0, res_valid}, {31'd0, ok});
    chk("R10 err", {31'd0, err}, {31'd0, e});
  endtask

  task automatic look(input string req, input bit r);
    sr = r;
    #1;
    chk({req, " res0"}, res0, rd(m0, mpk, r));
    chk({req, " res1"}, res1, rd(m1, mpk, r));
  endtask

  task automatic t_reset;
    sr = 1;
    #1;
    chk("R1 res0", res0, 32'd0);
    chk("R1 res1", res1, 32'd0);
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_full;
    op(32'h0003_0000, 32'h0002_0000, 0, 1, 1);
    look("R2 first", 1);
    op(32'hFFFF_0000, 32'h0005_0000, 0, 1, 0);
    look("R2 accumulate", 1);
    op(32'h0001_8000, 32'hFFFD_0000, 0, 1, 0);
    look("R2 negative", 1);
    look("R6 includes sample", 0);
  endtask

  task automatic t_hold;
    op(32'h1234_5678, 32'h0100_0000, 0, 0, 0);
    look("R11 hold", 1);
  endtask

  task automatic t_clear;
    op(32'h0, 32'h0, 0, 0, 1);
    look("R5 clear", 1);
    chk("R5 zero", res0, 32'd0);
  endtask

  task automatic t_packed;
    op({16'hFFFD, 16'h0005}, 32'h0002_0000, 1, 1, 0);
    look("R3 lanes", 1);
    op({16'h0007, 16'hFFFE}, 32'hFFFF_8000, 1, 1, 0);
    look("R3 accumulate", 1);
    op({16'h0100, 16'h0001}, 32'h0003_0000, 1, 1, 1);
    look("R5 clear with valid", 1);
  endtask

  task automatic t_nocarry;
    op({16'h0001, 16'h8000}, 32'h7FFF_FFFF, 1, 1, 1);
    for (int i = 0; i < 3; i++) op({16'h0001, 16'h8000}, 32'h7FFF_FFFF, 1, 1, 0);
    look("R4 lanes isolated", 0);
    look("R4 lanes isolated sat", 1);
  endtask

  task automatic t_moderr;
    op(32'h0004_0000, 32'h0001_0000, 0, 1, 0);
    look("R10 refused keeps acc", 1);
    op(32'h0004_0000, 32'h0001_0000, 0, 1, 1);
    look("R10 switch with clear", 1);
  endtask

  task automatic t_round;
    op(32'd5, 32'h0000_8000, 0, 1, 1);
    look("R7 tie up", 1);
    look("R9 floor", 0);
    op(32'hFFFF_FFFF, 32'h0000_4000, 0, 1, 1);
    look("R7 small neg", 1);
    look("R9 floor neg", 0);
    op(32'hFFFF_FFFB, 32'h0000_8000, 0, 1, 1);
    look("R7 tie away neg", 1);
  endtask

  task automatic t_sat;
    op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 1);
    look("R8 full high", 1);
    look("R9 full wrap", 0);
    op(32'h8000_0000, 32'h7FFF_FFFF, 0, 1, 1);
    look("R8 full low", 1);
    op({16'h8000, 16'h7FFF}, 32'h7FFF_FFFF, 1, 1, 1);
    look("R8 packed", 1);
    look("R9 packed wrap", 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 0; act = 0; wgt = 0; pk_in = 0; valid = 0; clear = 0; sr = 1;
    m0 = 0; m1 = 0; mpk = 0; mempty = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full();
    t_hold();
    t_clear();
    t_packed();
    t_nocarry();
    t_moderr();
    t_round();
    t_sat();
    finish_run();
  end
endmodule